// File: doc/BRIEF.md
# Bit-Serial Byte Arithmetic Unit

This unit performs 8-bit add, subtract, AND and OR through a datapath that is one bit wide. A request presents two operands in parallel. The unit copies them into internal shift registers. It then moves one bit pair per clock, least significant bit first, through a single-bit arithmetic/logic cell. The result bits are collected in a shift register. When the last bit has been processed, the whole byte goes to a held result register, and the carry, zero, sign and parity flags are updated at the same edge.

Requests are framed by a plain start/done handshake. The unit cannot apply back-pressure through a ready signal. Instead, a start that arrives while the unit is busy is discarded. A caller waits for `done_o`, or for `busy_o` to be low, before it issues the next request. `done_o` is a single-cycle pulse and no acknowledge is needed. The result and flags stay valid until the next operation completes, so a caller that misses the pulse can still read them later.

Wider values are processed one byte at a time, low byte first. The caller raises `chain_i` on every byte after the first. The carry or borrow left by the previous byte then feeds into the current one.

Top module: `serial_alu`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `result_o`, `carry_o`, `zero_o`, `sign_o` and `parity_o` are all 0.
- R2: A start is accepted on a rising clock edge where `start_i` is 1 and `busy_o` is 0. From the next cycle `busy_o` is 1. `done_o` is 1 for exactly one cycle, beginning DATA_W clocks after the accepting edge, and `busy_o` is 0 during that cycle. A start given during the done cycle is accepted.
- R3: A `start_i` given while `busy_o` is 1 is ignored. The running operation keeps its operands and its timing, and no extra done pulse follows it.
- R4: With `op_i` = 2'b00 (add), `result_o` is (A + B + cin) modulo 256, and `carry_o` is the carry out of bit 7.
- R5: With `op_i` = 2'b01 (subtract), `result_o` is (A − B − cin) modulo 256, and `carry_o` is 1 when a borrow occurred (for cin = 0, when A < B).
- R6: With `op_i` = 2'b10 the result is the bitwise AND, and with `op_i` = 2'b11 it is the bitwise OR. Both clear `carry_o`.
- R7: `zero_o` is 1 exactly when the completed result is 0.
- R8: `sign_o` equals bit 7 of the completed result.
- R9: `parity_o` is 1 exactly when the completed result holds an even number of 1 bits.
- R10: cin is `carry_o` as it stands at the accepting edge when `chain_i` is 1, and 0 when `chain_i` is 0. A prior carry therefore has no effect on an unchained operation.
- R11: `result_o` and the flags change only at the edge that raises `done_o`. They hold their values while a later operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an operation (ignored while busy) |
| op_i | input | 2 | 00 add, 01 subtract, 10 AND, 11 OR |
| chain_i | input | 1 | Use the previous carry/borrow as carry-in |
| opa_i | input | DATA_W | Operand A |
| opb_i | input | DATA_W | Operand B |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DATA_W | Held result byte |
| carry_o | output | 1 | Carry (add) or borrow (subtract); 0 after logic ops |
| zero_o | output | 1 | Result is zero |
| sign_o | output | 1 | Result bit 7 |
| parity_o | output | 1 | Result has even parity |

## Verification
The bench builds the unit with DATA_W = 8, the byte width the requirements are written for. At this width, boundary operands such as 0xFF + 0x01, 0x80 + 0x80 and equal operands under subtraction produce the carry, zero and sign corner cases within eight-clock operations. Two-byte add and subtract chains then exercise carry and borrow propagation across a byte boundary. The same width also places a start issued mid-operation at a known bit position, and keeps the back-to-back start in the done cycle within a few clocks.

// File: rtl/sal_pkg.sv
package sal_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;
endpackage

// File: rtl/sal_opshift.sv
// Parallel-load operand register that presents its low bit and shifts right.
module sal_opshift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         lsb
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {1'b0, q[W-1:1]};
  end

  assign lsb = q[0];
endmodule

// File: rtl/sal_bitcell.sv
// One-bit arithmetic/logic cell.
module sal_bitcell
  import sal_pkg::*;
(
  input  alu_op_e op,
  input  logic    a,
  input  logic    b,
  input  logic    cin,
  output logic    y,
  output logic    cout
);
  logic b_eff;

  always_comb begin
    b_eff = (op == OP_SUB) ? ~b : b;
    y     = 1'b0;
    cout  = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        y    = a ^ b_eff ^ cin;
        cout = (a & b_eff) | (cin & (a ^ b_eff));
      end
      OP_AND: y = a & b;
      OP_OR:  y = a | b;
      default: y = 1'b0;
    endcase
  end
endmodule

// File: rtl/sal_seq.sv
// Bit counter and start/done framing.
module sal_seq #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] cnt;

  assign accept = start && !busy;
  assign step   = busy;
  assign last   = busy && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        cnt  <= CNT_W'(W);
        busy <= 1'b1;
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sal_flags.sv
// Running carry plus zero/parity accumulation; flags written on the last bit.
module sal_flags
  import sal_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    accept,
  input  logic    seed,
  input  logic    step,
  input  logic    last,
  input  alu_op_e op,
  input  logic    ybit,
  input  logic    cout,
  output logic    crun,
  output logic    carry_f,
  output logic    zero_f,
  output logic    sign_f,
  output logic    parity_f
);
  logic z_acc, p_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crun     <= 1'b0;
      z_acc    <= 1'b0;
      p_acc    <= 1'b0;
      carry_f  <= 1'b0;
      zero_f   <= 1'b0;
      sign_f   <= 1'b0;
      parity_f <= 1'b0;
    end else if (accept) begin
      crun  <= seed;
      z_acc <= 1'b0;
      p_acc <= 1'b0;
    end else if (step) begin
      crun  <= cout;
      z_acc <= z_acc | ybit;
      p_acc <= p_acc ^ ybit;
      if (last) begin
        unique case (op)
          OP_ADD:  carry_f <= cout;
          OP_SUB:  carry_f <= ~cout;
          default: carry_f <= 1'b0;
        endcase
        zero_f   <= ~(z_acc | ybit);
        parity_f <= ~(p_acc ^ ybit);
        sign_f   <= ybit;
      end
    end
  end
endmodule

// File: rtl/serial_alu.sv
module serial_alu
  import sal_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              chain_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              sign_o,
  output logic              parity_o
);
  localparam int NOPS = 2;

  logic accept, step, last;
  logic [NOPS-1:0] bit_lsb;
  logic [NOPS-1:0][DATA_W-1:0] op_din;
  alu_op_e op_q;
  logic seed, crun, ybit, cout;
  logic [DATA_W-2:0] res_sh;

  sal_seq #(.W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_i),
    .accept(accept), .step(step), .last(last),
    .busy(busy_o), .done(done_o)
  );

  assign op_din[0] = opa_i;
  assign op_din[1] = opb_i;

  for (genvar i = 0; i < NOPS; i++) begin : g_operand
    sal_opshift #(.W(DATA_W)) u_sh (
      .clk(clk), .rst_n(rst_n), .load(accept), .shift(step),
      .din(op_din[i]), .lsb(bit_lsb[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      op_q <= OP_ADD;
    else if (accept) op_q <= alu_op_e'(op_i);
  end

  // Carry-in seed: subtraction runs as A + ~B + 1, so a borrow in means seed 0.
  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_ADD:  seed = chain_i & carry_o;
      OP_SUB:  seed = ~(chain_i & carry_o);
      default: seed = 1'b0;
    endcase
  end

  sal_bitcell u_cell (
    .op(op_q), .a(bit_lsb[0]), .b(bit_lsb[1]), .cin(crun),
    .y(ybit), .cout(cout)
  );

  sal_flags u_flags (
    .clk(clk), .rst_n(rst_n), .accept(accept), .seed(seed),
    .step(step), .last(last), .op(op_q), .ybit(ybit), .cout(cout),
    .crun(crun), .carry_f(carry_o), .zero_f(zero_o),
    .sign_f(sign_o), .parity_f(parity_o)
  );

  // Result collection: the low DATA_W-1 bits are gathered, the top bit
  // joins them directly on the final step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_sh   <= '0;
      result_o <= '0;
    end else if (step) begin
      if (last) result_o <= {ybit, res_sh};
      else      res_sh   <= {ybit, res_sh[DATA_W-2:1]};
    end
  end
endmodule

// File: rtl/sal_checker.sv
module sal_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [1:0]        op_i,
  input logic              chain_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              zero_o,
  input logic              sign_o,
  input logic              parity_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              acc;
  logic              run;
  logic [CNT_W-1:0]  cyc;
  logic [1:0]        l_op;
  logic [DATA_W-1:0] l_a, l_b;
  logic              l_cin;
  logic [DATA_W:0]   sum_exp, dif_exp;

  assign acc = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; cyc <= '0; l_op <= '0; l_a <= '0; l_b <= '0; l_cin <= 1'b0;
    end else if (acc) begin
      run <= 1'b1; cyc <= '0; l_op <= op_i; l_a <= opa_i; l_b <= opb_i;
      l_cin <= chain_i & carry_o;
    end else if (done_o) begin
      run <= 1'b0;
    end else if (run) begin
      cyc <= cyc + CNT_W'(1);
    end
  end

  assign sum_exp = {1'b0, l_a} + {1'b0, l_b} + {{DATA_W{1'b0}}, l_cin};
  assign dif_exp = {1'b0, l_a} - {1'b0, l_b} - {{DATA_W{1'b0}}, l_cin};

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy_o);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run && cyc == CNT_W'(DATA_W) && !busy_o));
  assert_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && l_op == 2'b00) |-> ({carry_o, result_o} == sum_exp));
  assert_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && l_op == 2'b01) |-> ({carry_o, result_o} == dif_exp));
  assert_logic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && l_op[1]) |-> (!carry_o &&
      result_o == (l_op[0] ? (l_a | l_b) : (l_a & l_b))));
  assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (zero_o == (result_o == '0)));
  assert_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sign_o == result_o[DATA_W-1]));
  assert_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (parity_o == ~^result_o));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(carry_o) && $stable(zero_o)
                 && $stable(sign_o) && $stable(parity_o)));
endmodule

bind serial_alu sal_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .chain_i(chain_i),
  .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
  .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o), .sign_o(sign_o),
  .parity_o(parity_o)
);

// File: tb/serial_alu_tb.sv
module serial_alu_tb;
  import sal_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic       chain_i = 1'b0;
  logic [7:0] opa_i = '0, opb_i = '0;
  logic       busy_o, done_o, carry_o, zero_o, sign_o, parity_o;
  logic [7:0] result_o;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  finished = 0;
  logic       exp_c = 1'b0;
  logic [7:0] prev_r = '0;

  always #2.5 clk = ~clk;

  serial_alu #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .chain_i(chain_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o), .sign_o(sign_o),
    .parity_o(parity_o)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_reset();
    // R1: all outputs low out of reset
    chk({busy_o, done_o, result_o, carry_o, zero_o, sign_o, parity_o} == '0,
        "R1 reset outputs",
        {3'b0, busy_o, done_o, result_o, carry_o, zero_o, sign_o, parity_o}, 16'h0);
  endtask

  // Drive one operation and check timing, result and flags.
  task automatic run_op(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic chain, input bit intrude, input string req);
    logic [8:0] w;
    logic [7:0] r;
    logic       c, cin;
    bit         early;
    cin = chain ? exp_c : 1'b0;  // R10
    case (op)
      2'b00: begin w = {1'b0, a} + {1'b0, b} + {8'b0, cin}; r = w[7:0]; c = w[8]; end
      2'b01: begin w = {1'b0, a} - {1'b0, b} - {8'b0, cin}; r = w[7:0]; c = w[8]; end
      2'b10: begin r = a & b; c = 1'b0; end
      default: begin r = a | b; c = 1'b0; end
    endcase
    op_i = op; opa_i = a; opb_i = b; chain_i = chain; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", {15'b0, busy_o}, 16'h1);
    early = 0;
    for (int k = 1; k <= 8; k++) begin
      if (intrude && k == 3) begin
        op_i = 2'b11; opa_i = ~a; opb_i = 8'h5A; chain_i = 1'b0; start_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
      if (k == 4)
        chk(result_o == prev_r, "R11 result held while running", {8'b0, result_o}, {8'b0, prev_r});
      if (k < 8 && done_o) early = 1;
    end
    chk(done_o && !busy_o && !early, "R2 done after 8 clocks",
        {14'b0, done_o, busy_o}, 16'h2);
    chk(result_o == r, {req, " result"}, {8'b0, result_o}, {8'b0, r});
    chk(carry_o == c, {req, " carry"}, {15'b0, carry_o}, {15'b0, c});
    chk(zero_o == (r == 8'h00), "R7 zero flag", {15'b0, zero_o}, {15'b0, (r == 8'h00)});
    chk(sign_o == r[7], "R8 sign flag", {15'b0, sign_o}, {15'b0, r[7]});
    chk(parity_o == ~^r, "R9 parity flag", {15'b0, parity_o}, {15'b0, ~^r});
    exp_c = c;
    prev_r = r;
    if (intrude) begin
      early = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (done_o || busy_o) early = 1;
      end
      chk(!early && result_o == r, "R3 start while busy ignored",
          {8'b0, result_o}, {8'b0, r});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();
    // R4 add patterns, including overflow to zero and sign boundary
    run_op(2'b00, 8'h35, 8'h4A, 1'b0, 0, "R4 add");
    run_op(2'b00, 8'hFF, 8'h01, 1'b0, 0, "R4 add wrap");
    run_op(2'b00, 8'h80, 8'h80, 1'b0, 0, "R4 add msb");
    // R10: carry is set, unchained add ignores it
    run_op(2'b00, 8'h01, 8'h01, 1'b0, 0, "R10 unchained add");
    // R5 subtract patterns
    run_op(2'b01, 8'h05, 8'h03, 1'b0, 0, "R5 sub");
    run_op(2'b01, 8'h03, 8'h05, 1'b0, 0, "R5 sub borrow");
    run_op(2'b01, 8'h7C, 8'h7C, 1'b0, 0, "R5 sub equal");
    // R6 logic ops; first make carry set, then AND must clear it
    run_op(2'b00, 8'hF0, 8'h20, 1'b0, 0, "R4 add carry");
    run_op(2'b10, 8'hC3, 8'hA5, 1'b0, 0, "R6 and");
    run_op(2'b11, 8'h0C, 8'h30, 1'b0, 0, "R6 or");
    run_op(2'b10, 8'h0F, 8'hF0, 1'b0, 0, "R6 and zero");
    // R10 two-byte add 0x12FF + 0x0001 and subtract 0x1000 - 0x0001
    run_op(2'b00, 8'hFF, 8'h01, 1'b0, 0, "R10 add low byte");
    run_op(2'b00, 8'h12, 8'h00, 1'b1, 0, "R10 add high byte");
    run_op(2'b01, 8'h00, 8'h01, 1'b0, 0, "R10 sub low byte");
    run_op(2'b01, 8'h10, 8'h00, 1'b1, 0, "R10 sub high byte");
    // R3: a second start mid-operation must not disturb it
    run_op(2'b00, 8'h21, 8'h12, 1'b0, 1, "R3 add under intrusion");
    run_op(2'b01, 8'h40, 8'h01, 1'b0, 0, "R5 sub after idle");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule